// File: doc/BRIEF.md
# Fused-Operation Functional Unit Slice

This block is a one-dimensional slice of a coarse-grained reconfigurable array. It has six single-cycle functional units that share an eight-entry, 16-bit register file. A small configuration memory holds a program of wide words, one word per clock. Each word sets the opcode of every unit, the source of each operand, the register indices, an immediate, a destination and a write enable. A start pulse runs the program from word 0. The run ends after the word that carries the end-of-program bit has committed its writes, and a one-cycle done pulse follows.

A unit normally reads its operands from the register file, from its immediate, or as zero, and its result is written back at the clock edge. A unit can also take the combinational result of the unit just below it. A run of linked units then forms a fused chain that evaluates several dependent operations within a single clock. Only the last unit of a chain writes back. Separate chains in one word work side by side. A chain longer than three units, a link on unit 0, or a multi-cycle opcode inside a chain makes the word illegal. An illegal word performs no writes, stops the run and raises an error flag.

Top module: `fx_fuse_slice`

## Requirements
- R1: After reset every register entry reads 0, and `done` and `err` are low.
- R2: A preload write (`pre_we`) while no program runs stores `pre_data` at entry `pre_addr`. While a program runs, preload writes are ignored. Entry k appears on `rf_state[16k+15:16k]`.
- R3: Opcodes: 0 NOP (no write), 1 ADD, 2 SUB (a-b), 3 LSL, 4 LSR, 5 ASR, 6 EQ, 7 NE, 8 LT, 9 AND, 10 OR, 11 XOR. Opcodes 12 to 15 are multi-cycle and never write.
- R4: Shift amounts use only bits 3:0 of operand b. ASR replicates the sign bit. LT compares as signed. EQ, NE and LT give 1 or 0.
- R5: Operand select codes: 0 register, 1 immediate zero-extended, 2 result of unit i-1 in the same cycle, 3 zero. Unit i occupies word bits [26i+25:26i]. Its fields, from MSB down, are opcode (4), select a (2), select b (2), ra (3), rb (3), imm (8), dst (3) and wen (1). Bit 156 is end-of-program.
- R6: One word executes per clock. `done` is high for exactly one cycle, starting N cycles after the start edge for a legal program of N words.
- R7: In a fused chain, only the last unit writes. A unit whose result feeds the next unit writes nothing.
- R8: Two independent fused chains in one word both commit their final results in that cycle.
- R9: When several units write the same entry in one cycle, the highest-numbered unit's value is stored.
- R10: A chain of more than 3 linked units sets `err`, performs no write in that word, and ends the run without `done`.
- R11: A multi-cycle opcode in a unit that feeds or takes a link, or a link requested by unit 0, sets `err` and performs no writes.
- R12: `err` stays high until the next start, which clears it.
- R13: The six-operation reference graph (SUB, ADD, ADD, LSR, LSL, ADD) takes 5 cycles as an unfused program and 3 cycles fused, and both leave identical register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration memory write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 157 | Configuration word to store |
| start | input | 1 | Starts the program at word 0 when idle |
| pre_we | input | 1 | Register preload write strobe |
| pre_addr | input | 3 | Preload entry index |
| pre_data | input | 16 | Preload value |
| rf_state | output | 128 | All register entries, entry k in bits 16k+15:16k |
| done | output | 1 | One-cycle pulse after the last word commits |
| err | output | 1 | Illegal configuration word seen, held until next start |

## Verification
The reference graph runs twice. The first run is an unfused five-word program and the second a three-word version with two side-by-side chains, so cycle count and register contents separate a working bypass from one that falls back to registered operands. Two words with six unfused operations each separate every opcode, the signed compare, sign fill and the 4-bit shift mask. A 3+3 chain word tells apart suppression of intermediate writes and concurrency of chains. A same-entry collision checks write priority. Over-long chains and a fused multi-cycle opcode must leave the registers untouched and raise the flag, and the next run must clear the flag.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int NUM_FU   = 6;
  localparam int DATA_W   = 16;
  localparam int RF_DEPTH = 8;
  localparam int RIDX_W   = $clog2(RF_DEPTH);
  localparam int IMM_W    = 8;
  localparam int OP_W     = 4;
  localparam int SHAMT_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 4'd0,  OP_ADD = 4'd1,  OP_SUB = 4'd2,  OP_LSL = 4'd3,
    OP_LSR = 4'd4,  OP_ASR = 4'd5,  OP_EQ  = 4'd6,  OP_NE  = 4'd7,
    OP_LT  = 4'd8,  OP_AND = 4'd9,  OP_OR  = 4'd10, OP_XOR = 4'd11,
    OP_MUL = 4'd12, OP_LD  = 4'd13, OP_ST  = 4'd14, OP_RSV = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0, SRC_IMM = 2'd1, SRC_BYP = 2'd2, SRC_ZERO = 2'd3
  } src_e;

  typedef struct packed {
    op_e               op;
    src_e              sel_a;
    src_e              sel_b;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [IMM_W-1:0]  imm;
    logic [RIDX_W-1:0] dst;
    logic              wen;
  } ucfg_t;

  localparam int UCFG_W = $bits(ucfg_t);
  localparam int WORD_W = NUM_FU * UCFG_W + 1;

  function automatic logic is_multi(op_e op);
    return op >= OP_MUL;
  endfunction

  function automatic logic [DATA_W-1:0] pick_src(src_e s, logic [DATA_W-1:0] r,
                                                 logic [IMM_W-1:0] imm,
                                                 logic [DATA_W-1:0] byp);
    case (s)
      SRC_REG: return r;
      SRC_IMM: return {{(DATA_W-IMM_W){1'b0}}, imm};
      SRC_BYP: return byp;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/fx_alu.sv
module fx_alu
  import fx_pkg::*;
(
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  logic [SHAMT_W-1:0] sh;
  assign sh = b[SHAMT_W-1:0];

  always_comb begin
    case (op)
      OP_ADD: y = a + b;
      OP_SUB: y = a - b;
      OP_LSL: y = a << sh;
      OP_LSR: y = a >> sh;
      OP_ASR: y = $unsigned($signed(a) >>> sh);
      OP_EQ:  y = {{(DATA_W-1){1'b0}}, (a == b)};
      OP_NE:  y = {{(DATA_W-1){1'b0}}, (a != b)};
      OP_LT:  y = {{(DATA_W-1){1'b0}}, ($signed(a) < $signed(b))};
      OP_AND: y = a & b;
      OP_OR:  y = a | b;
      OP_XOR: y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/fx_chain_ctl.sv
module fx_chain_ctl
  import fx_pkg::*;
#(
  parameter int MAX_CHAIN = 3
) (
  input  ucfg_t             ucfg [NUM_FU],
  output logic [NUM_FU-1:0] commit,
  output logic              illegal
);
  logic [NUM_FU-1:0] linked;
  logic [NUM_FU-1:0] feeds;
  logic [NUM_FU-1:0] fused;

  always_comb begin
    for (int i = 0; i < NUM_FU; i++) begin
      linked[i] = (ucfg[i].sel_a == SRC_BYP) || (ucfg[i].sel_b == SRC_BYP);
    end
  end

  assign feeds = {1'b0, linked[NUM_FU-1:1]};
  assign fused = linked | feeds;

  always_comb begin
    int run;
    run = 0;
    illegal = linked[0];
    for (int i = 0; i < NUM_FU; i++) begin
      run = linked[i] ? run + 1 : 1;
      if (run > MAX_CHAIN) illegal = 1'b1;
      if (fused[i] && is_multi(ucfg[i].op)) illegal = 1'b1;
    end
    for (int i = 0; i < NUM_FU; i++) begin
      commit[i] = ucfg[i].wen && !feeds[i] && (ucfg[i].op != OP_NOP) &&
                  !is_multi(ucfg[i].op) && !illegal;
    end
  end
endmodule

// File: rtl/fx_regfile.sv
module fx_regfile
  import fx_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pre_we,
  input  logic [RIDX_W-1:0]          pre_addr,
  input  logic [DATA_W-1:0]          pre_data,
  input  logic [NUM_FU-1:0]          wr_en,
  input  logic [RIDX_W-1:0]          wr_addr [NUM_FU],
  input  logic [DATA_W-1:0]          wr_data [NUM_FU],
  input  logic [RIDX_W-1:0]          raddr_a [NUM_FU],
  input  logic [RIDX_W-1:0]          raddr_b [NUM_FU],
  output logic [DATA_W-1:0]          rdata_a [NUM_FU],
  output logic [DATA_W-1:0]          rdata_b [NUM_FU],
  output logic [RF_DEPTH*DATA_W-1:0] state
);
  logic [DATA_W-1:0] mem [RF_DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < RF_DEPTH; k++) mem[k] <= '0;
    end else begin
      if (pre_we) mem[pre_addr] <= pre_data;
      for (int u = 0; u < NUM_FU; u++) begin
        if (wr_en[u]) mem[wr_addr[u]] <= wr_data[u];
      end
    end
  end

  for (genvar u = 0; u < NUM_FU; u++) begin : g_rd
    assign rdata_a[u] = mem[raddr_a[u]];
    assign rdata_b[u] = mem[raddr_b[u]];
  end

  for (genvar k = 0; k < RF_DEPTH; k++) begin : g_st
    assign state[k*DATA_W +: DATA_W] = mem[k];
  end
endmodule

// File: rtl/fx_fuse_slice.sv
module fx_fuse_slice
  import fx_pkg::*;
#(
  parameter int PROG_DEPTH = 16,
  parameter int MAX_CHAIN  = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [$clog2(PROG_DEPTH)-1:0] cfg_addr,
  input  logic [WORD_W-1:0]             cfg_wdata,
  input  logic                          start,
  input  logic                          pre_we,
  input  logic [RIDX_W-1:0]             pre_addr,
  input  logic [DATA_W-1:0]             pre_data,
  output logic [RF_DEPTH*DATA_W-1:0]    rf_state,
  output logic                          done,
  output logic                          err
);
  localparam int PC_W = $clog2(PROG_DEPTH);

  logic [WORD_W-1:0] cmem [PROG_DEPTH];
  logic [PC_W-1:0]   pc;
  logic              busy;
  logic [WORD_W-1:0] word;
  logic              end_bit;
  ucfg_t             ucfg [NUM_FU];
  logic [NUM_FU-1:0] commit;
  logic              illegal;

  logic [DATA_W-1:0] fu_res  [NUM_FU];
  logic [RIDX_W-1:0] ra_v    [NUM_FU];
  logic [RIDX_W-1:0] rb_v    [NUM_FU];
  logic [RIDX_W-1:0] dst_v   [NUM_FU];
  logic [DATA_W-1:0] rd_a    [NUM_FU];
  logic [DATA_W-1:0] rd_b    [NUM_FU];

  always_ff @(posedge clk) begin
    if (cfg_we) cmem[cfg_addr] <= cfg_wdata;
  end

  assign word    = cmem[pc];
  assign end_bit = word[WORD_W-1];

  for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
    logic [DATA_W-1:0] byp;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;

    assign ucfg[g] = word[g*UCFG_W +: UCFG_W];

    if (g == 0) begin : g_head
      assign byp = '0;
    end else begin : g_link
      assign byp = fu_res[g-1];
    end

    assign opa   = pick_src(ucfg[g].sel_a, rd_a[g], ucfg[g].imm, byp);
    assign opb   = pick_src(ucfg[g].sel_b, rd_b[g], ucfg[g].imm, byp);
    assign ra_v[g]  = ucfg[g].ra;
    assign rb_v[g]  = ucfg[g].rb;
    assign dst_v[g] = ucfg[g].dst;

    fx_alu u_alu (
      .op (ucfg[g].op),
      .a  (opa),
      .b  (opb),
      .y  (fu_res[g])
    );
  end

  fx_chain_ctl #(.MAX_CHAIN(MAX_CHAIN)) u_ctl (
    .ucfg    (ucfg),
    .commit  (commit),
    .illegal (illegal)
  );

  fx_regfile u_rf (
    .clk      (clk),
    .rst      (rst),
    .pre_we   (pre_we && !busy),
    .pre_addr (pre_addr),
    .pre_data (pre_data),
    .wr_en    (commit & {NUM_FU{busy}}),
    .wr_addr  (dst_v),
    .wr_data  (fu_res),
    .raddr_a  (ra_v),
    .raddr_b  (rb_v),
    .rdata_a  (rd_a),
    .rdata_b  (rd_b),
    .state    (rf_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      pc   <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          pc   <= '0;
          err  <= 1'b0;
        end
      end else if (illegal) begin
        busy <= 1'b0;
        err  <= 1'b1;
      end else if (end_bit) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fx_fuse_chk.sv
module fx_fuse_chk
  import fx_pkg::*;
(
  input logic                       clk,
  input logic                       rst,
  input logic                       busy,
  input logic                       illegal,
  input logic                       end_bit,
  input logic                       pre_we,
  input logic                       done,
  input logic                       err,
  input logic [RF_DEPTH*DATA_W-1:0] rf_state
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    busy && end_bit && !illegal |=> done); // R6

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    busy && illegal |=> $stable(rf_state)); // R10

  AST_ILLEGAL_FLAGS: assert property (@(posedge clk) disable iff (rst)
    busy && illegal |=> err && !busy); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !busy && !pre_we |=> $stable(rf_state)); // R2

  AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
    done |-> !err); // R12
endmodule

bind fx_fuse_slice fx_fuse_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .illegal  (illegal),
  .end_bit  (end_bit),
  .pre_we   (pre_we),
  .done     (done),
  .err      (err),
  .rf_state (rf_state)
);

// File: tb/test_fx_fuse_slice.sv
module test_fx_fuse_slice;
  import fx_pkg::*;

  logic                       clk = 1'b0;
  logic                       rst = 1'b1;
  logic                       cfg_we = 1'b0;
  logic [3:0]                 cfg_addr = '0;
  logic [WORD_W-1:0]          cfg_wdata = '0;
  logic                       start = 1'b0;
  logic                       pre_we = 1'b0;
  logic [RIDX_W-1:0]          pre_addr = '0;
  logic [DATA_W-1:0]          pre_data = '0;
  logic [RF_DEPTH*DATA_W-1:0] rf_state;
  logic                       done;
  logic                       err;

  int total = 0;
  int bad = 0;

  ucfg_t pu [8][NUM_FU];

  always #10 clk = ~clk;

  fx_fuse_slice i_fx_fuse_slice (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .pre_we(pre_we),
    .pre_addr(pre_addr), .pre_data(pre_data), .rf_state(rf_state),
    .done(done), .err(err)
  );

  function automatic logic [DATA_W-1:0] rd(int k);
    return rf_state[k*DATA_W +: DATA_W];
  endfunction

  function automatic ucfg_t mk(op_e op, src_e sa, src_e sb, int ra, int rb,
                               int imm, int dst, logic wen);
    ucfg_t u;
    u.op = op; u.sel_a = sa; u.sel_b = sb;
    u.ra = RIDX_W'(ra); u.rb = RIDX_W'(rb); u.imm = IMM_W'(imm);
    u.dst = RIDX_W'(dst); u.wen = wen;
    return u;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int w = 0; w < 8; w++)
      for (int u = 0; u < NUM_FU; u++) pu[w][u] = '0;
  endtask

  task automatic preload(int a, logic [DATA_W-1:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = RIDX_W'(a); pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic seed_ab();
    for (int k = 0; k < RF_DEPTH; k++) preload(k, 16'h0000);
  endtask

  // Loads n words (end bit on the last), starts, counts cycles to done/err.
  task automatic run(int n, logic poke, output int cyc, output logic gd,
                     output logic ge);
    for (int w = 0; w < n; w++) begin
      logic [WORD_W-1:0] wd;
      wd = '0;
      for (int u = 0; u < NUM_FU; u++) wd[u*UCFG_W +: UCFG_W] = pu[w][u];
      wd[WORD_W-1] = (w == n - 1);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'(w); cfg_wdata = wd;
    end
    @(negedge clk);
    cfg_we = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      pre_we = 1'b1; pre_addr = '0; pre_data = 16'hFFFF;
    end
    cyc = 0; gd = 1'b0; ge = 1'b0;
    for (int t = 0; t < 50; t++) begin
      @(negedge clk);
      pre_we = 1'b0;
      cyc++;
      if (done || err) begin
        gd = done; ge = err;
        break;
      end
    end
  endtask

  task automatic t_reset();
    for (int k = 0; k < RF_DEPTH; k++) chk("R1 entry zero", 32'(rd(k)), 32'h0);
    chk("R1 done low", 32'(done), 32'h0);
    chk("R1 err low", 32'(err), 32'h0);
  endtask

  task automatic t_preload();
    for (int k = 0; k < RF_DEPTH; k++) preload(k, 16'(16'h1100 + k * 16'h0101));
    for (int k = 0; k < RF_DEPTH; k++)
      chk("R2 preload", 32'(rd(k)), 32'(16'h1100 + k * 16'h0101));
  endtask

  task automatic ref_expect(string tag);
    chk({tag, " r0"}, 32'(rd(0)), 32'h1234);
    chk({tag, " r1"}, 32'(rd(1)), 32'h0050);
    chk({tag, " r2"}, 32'(rd(2)), 32'h9426);
    chk({tag, " r3"}, 32'(rd(3)), 32'h1200);
    chk({tag, " r4"}, 32'(rd(4)), 32'h0060);
    chk({tag, " r5"}, 32'(rd(5)), 32'h0126);
    chk({tag, " r6"}, 32'(rd(6)), 32'h9300);
    chk({tag, " r7"}, 32'(rd(7)), 32'h1260);
  endtask

  task automatic t_ref_conv();
    int c; logic gd, ge;
    seed_ab(); preload(0, 16'h1234); preload(1, 16'h0050);
    clear_prog();
    pu[0][0] = mk(OP_SUB, SRC_REG, SRC_IMM, 0, 0, 8'h34, 3, 1);
    pu[0][1] = mk(OP_ADD, SRC_REG, SRC_IMM, 1, 0, 8'h10, 4, 1);
    pu[1][0] = mk(OP_ADD, SRC_REG, SRC_REG, 3, 4, 0, 7, 1);
    pu[2][0] = mk(OP_LSR, SRC_REG, SRC_IMM, 7, 0, 4, 5, 1);
    pu[3][0] = mk(OP_LSL, SRC_REG, SRC_IMM, 7, 0, 3, 6, 1);
    pu[4][0] = mk(OP_ADD, SRC_REG, SRC_REG, 5, 6, 0, 2, 1);
    run(5, 1'b0, c, gd, ge);
    chk("R13 unfused cycles", 32'(c), 32'd5);
    chk("R6 unfused done", 32'(gd), 32'h1);
    ref_expect("R13 unfused");
  endtask

  task automatic t_ref_fused();
    int c; logic gd, ge;
    seed_ab(); preload(0, 16'h1234); preload(1, 16'h0050);
    clear_prog();
    pu[0][0] = mk(OP_SUB, SRC_REG, SRC_IMM, 0, 0, 8'h34, 3, 1);
    pu[0][1] = mk(OP_ADD, SRC_REG, SRC_IMM, 1, 0, 8'h10, 4, 1);
    pu[1][0] = mk(OP_ADD, SRC_REG, SRC_REG, 3, 4, 0, 0, 0);
    pu[1][1] = mk(OP_LSR, SRC_BYP, SRC_IMM, 0, 0, 4, 5, 1);
    pu[1][2] = mk(OP_ADD, SRC_REG, SRC_REG, 3, 4, 0, 0, 0);
    pu[1][3] = mk(OP_LSL, SRC_BYP, SRC_IMM, 0, 0, 3, 6, 1);
    pu[1][4] = mk(OP_ADD, SRC_REG, SRC_REG, 3, 4, 0, 7, 1);
    pu[2][0] = mk(OP_ADD, SRC_REG, SRC_REG, 5, 6, 0, 2, 1);
    run(3, 1'b1, c, gd, ge);
    chk("R13 fused cycles", 32'(c), 32'd3);
    @(negedge clk);
    chk("R6 done one cycle", 32'(done), 32'h0);
    ref_expect("R13 R8 fused");   // r0 intact also shows R2 busy preload ignored
  endtask

  task automatic t_ops();
    int c; logic gd, ge;
    preload(0, 16'h8F10); preload(1, 16'h0013);
    clear_prog();
    pu[0][0] = mk(OP_ASR, SRC_REG, SRC_REG, 0, 1, 0, 2, 1);
    pu[0][1] = mk(OP_LSL, SRC_REG, SRC_REG, 0, 1, 0, 3, 1);
    pu[0][2] = mk(OP_LT,  SRC_REG, SRC_REG, 0, 1, 0, 4, 1);
    pu[0][3] = mk(OP_XOR, SRC_REG, SRC_REG, 0, 1, 0, 5, 1);
    pu[0][4] = mk(OP_SUB, SRC_REG, SRC_REG, 1, 0, 0, 6, 1);
    pu[0][5] = mk(OP_NE,  SRC_REG, SRC_REG, 0, 1, 0, 7, 1);
    run(1, 1'b0, c, gd, ge);
    chk("R4 ASR sign fill", 32'(rd(2)), 32'hF1E2);
    chk("R4 LSL low bits", 32'(rd(3)), 32'h7880);
    chk("R4 LT signed", 32'(rd(4)), 32'h0001);
    chk("R3 XOR", 32'(rd(5)), 32'h8F03);
    chk("R3 SUB", 32'(rd(6)), 32'h7103);
    chk("R3 NE", 32'(rd(7)), 32'h0001);
    clear_prog();
    pu[0][0] = mk(OP_AND, SRC_REG, SRC_REG, 0, 1, 0, 2, 1);
    pu[0][1] = mk(OP_OR,  SRC_REG, SRC_REG, 0, 1, 0, 3, 1);
    pu[0][2] = mk(OP_EQ,  SRC_REG, SRC_REG, 0, 0, 0, 4, 1);
    pu[0][3] = mk(OP_LSR, SRC_REG, SRC_REG, 0, 1, 0, 5, 1);
    pu[0][4] = mk(OP_ADD, SRC_REG, SRC_IMM, 0, 0, 8'hF0, 6, 1);
    pu[0][5] = mk(OP_LT,  SRC_REG, SRC_REG, 1, 0, 0, 7, 1);
    run(1, 1'b0, c, gd, ge);
    chk("R3 AND", 32'(rd(2)), 32'h0010);
    chk("R3 OR", 32'(rd(3)), 32'h8F13);
    chk("R4 EQ", 32'(rd(4)), 32'h0001);
    chk("R4 LSR", 32'(rd(5)), 32'h11E2);
    chk("R5 imm zero-ext ADD", 32'(rd(6)), 32'h9000);
    chk("R4 LT false", 32'(rd(7)), 32'h0000);
  endtask

  task automatic t_chain3();
    int c; logic gd, ge;
    preload(4, 16'hAAAA);
    clear_prog();
    pu[0][0] = mk(OP_ADD, SRC_REG, SRC_IMM, 0, 0, 1, 4, 1);
    pu[0][1] = mk(OP_LSR, SRC_BYP, SRC_IMM, 0, 0, 4, 0, 0);
    pu[0][2] = mk(OP_AND, SRC_BYP, SRC_IMM, 0, 0, 8'hFF, 2, 1);
    pu[0][3] = mk(OP_SUB, SRC_REG, SRC_IMM, 1, 0, 3, 0, 0);
    pu[0][4] = mk(OP_LSL, SRC_BYP, SRC_IMM, 0, 0, 8'h14, 0, 0);
    pu[0][5] = mk(OP_OR,  SRC_BYP, SRC_REG, 0, 1, 0, 3, 1);
    run(1, 1'b0, c, gd, ge);
    chk("R8 chain cycles", 32'(c), 32'd1);
    chk("R8 R5 chain A", 32'(rd(2)), 32'h00F1);
    chk("R8 chain B", 32'(rd(3)), 32'h0113);
    chk("R7 intermediate suppressed", 32'(rd(4)), 32'hAAAA);
  endtask

  task automatic t_collide();
    int c; logic gd, ge;
    clear_prog();
    pu[0][0] = mk(OP_ADD, SRC_ZERO, SRC_IMM, 0, 0, 8'h33, 5, 1);
    pu[0][2] = mk(OP_ADD, SRC_ZERO, SRC_IMM, 0, 0, 8'h11, 5, 1);
    pu[0][3] = mk(OP_ADD, SRC_ZERO, SRC_IMM, 0, 0, 8'h44, 6, 1);
    pu[0][5] = mk(OP_ADD, SRC_ZERO, SRC_IMM, 0, 0, 8'h22, 5, 1);
    run(1, 1'b0, c, gd, ge);
    chk("R9 highest unit wins", 32'(rd(5)), 32'h0022);
    chk("R5 zero source", 32'(rd(6)), 32'h0044);
  endtask

  task automatic t_too_long();
    int c; logic gd, ge;
    preload(6, 16'h5555); preload(7, 16'h6666);
    clear_prog();
    pu[0][0] = mk(OP_ADD, SRC_REG, SRC_IMM, 0, 0, 1, 0, 0);
    pu[0][1] = mk(OP_ADD, SRC_BYP, SRC_IMM, 0, 0, 1, 0, 0);
    pu[0][2] = mk(OP_ADD, SRC_BYP, SRC_IMM, 0, 0, 1, 0, 0);
    pu[0][3] = mk(OP_ADD, SRC_BYP, SRC_IMM, 0, 0, 1, 6, 1);
    pu[0][5] = mk(OP_ADD, SRC_ZERO, SRC_IMM, 0, 0, 9, 7, 1);
    run(1, 1'b0, c, gd, ge);
    chk("R10 err raised", 32'(ge), 32'h1);
    chk("R10 no done", 32'(gd), 32'h0);
    chk("R10 chain dst untouched", 32'(rd(6)), 32'h5555);
    chk("R10 other unit untouched", 32'(rd(7)), 32'h6666);
  endtask

  task automatic t_multi();
    int c; logic gd, ge;
    preload(2, 16'h7777); preload(3, 16'h1111);
    clear_prog();
    pu[0][0] = mk(OP_MUL, SRC_REG, SRC_REG, 0, 1, 0, 2, 1);
    pu[0][1] = mk(OP_ADD, SRC_BYP, SRC_IMM, 0, 0, 1, 3, 1);
    run(1, 1'b0, c, gd, ge);
    chk("R11 err raised", 32'(ge), 32'h1);
    chk("R11 r2 untouched", 32'(rd(2)), 32'h7777);
    chk("R11 r3 untouched", 32'(rd(3)), 32'h1111);
    repeat (3) @(negedge clk);
    chk("R12 err held", 32'(err), 32'h1);
    clear_prog();
    pu[0][0] = mk(OP_ADD, SRC_ZERO, SRC_IMM, 0, 0, 5, 2, 1);
    run(1, 1'b0, c, gd, ge);
    chk("R12 err cleared", 32'(err), 32'h0);
    chk("R12 run completes", 32'(gd), 32'h1);
    chk("R12 write done", 32'(rd(2)), 32'h0005);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_preload();
    t_ref_conv();
    t_ref_fused();
    t_ops();
    t_chain3();
    t_collide();
    t_too_long();
    t_multi();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule